// File: doc/BRIEF.md
# Variable-Pulse-Width Symbol Transmitter

This block turns a stream of bytes into the level sequence of a single-wire variable-pulse-width bus. A frame opens with an active start-of-frame pulse. Each byte then goes out as eight symbols, most significant bit first. The bus level flips at every symbol boundary. The length of each symbol depends on two things: the bit it carries and the level it is sent at. When the final byte is done, the bus is released for an end-of-data period. The surrounding logic supplies all timing through a clock enable that pulses once per microsecond, so every duration below is a count of those ticks.

Bytes arrive through a valid/ready handshake, and a flag marks the last byte of a frame. A break request ends any frame in progress and drives a long active pulse. A busy flag tells the sender when the block is driving or is inside end-of-data. A new frame can start only after the bus has been passive for a set gap.

Top module: `vpw_tx`

## Requirements
- R1: While reset is high and in the cycle after it is released, bus_active is 0, busy is 0 and byte_ready is 0.
- R2: When a first byte is accepted in idle, bus_active becomes 1 at the next clock and stays 1 for exactly T_SOF (200) ticks.
- R3: Each data symbol lasts T_LONG (128) ticks for a 0 sent active or a 1 sent passive, and T_SHORT (64) ticks for a 1 sent active or a 0 sent passive. Bit 7 of each byte is sent first and bit 0 last.
- R4: The level flips at every symbol boundary. The first symbol of every byte is passive (bus_active 0), and the eighth symbol is active.
- R5: After the last byte's eighth symbol, bus_active is 0 for T_EOD (200) ticks while busy stays 1. Then busy drops to 0. busy is 0 only in idle.
- R6: During a frame, byte_ready is 1 only in the cycle where the eighth symbol of a byte that was not flagged last has its final tick. If byte_valid is 0 in that cycle, the frame ends as if that byte had been flagged last.
- R7: A brk_req seen while no break is running aborts the frame or idle state. bus_active becomes 1 at the next clock and holds for T_BRK (300) ticks, then returns to 0 in idle. brk_req during a running break has no effect, and byte_ready is 0 whenever brk_req is 1.
- R8: In idle, byte_ready is 1 only when the bus has been passive for at least T_GAP (300) consecutive ticks. Any active cycle restarts that count.
- R9: Symbol timers advance only on cycles with tick at 1. With tick held at 0, bus_active does not change except through a frame start or a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-microsecond timing enable |
| byte_data | input | 8 | Byte to send, bit 7 first |
| byte_valid | input | 1 | byte_data is offered |
| byte_last | input | 1 | Offered byte is the frame's last |
| byte_ready | output | 1 | Offered byte is taken this cycle if valid |
| brk_req | input | 1 | Request a break pulse |
| busy | output | 1 | Frame, end-of-data or break in progress |
| bus_active | output | 1 | Bus level, 1 = active (driven) |

## Verification
The hardest case to reach is the single cycle where a byte's eighth symbol ends. In that cycle the block either takes the next byte, or, when none is offered, turns the frame into end-of-data. The bench keeps byte_valid high across whole multi-byte frames so the hand-over happens at that edge. It also withdraws byte_valid after an early byte to force the underrun path. Breaks are requested in the middle of a frame, in idle, and held long enough to overlap their own pulse. The tick is run at one-in-one and one-in-three rates, and is frozen mid-symbol.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_BITS,
        ST_EOD,
        ST_BRK
    } vpw_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [IDX_W-1:0]  idx;
        logic              last;
    } vpw_shift_t;

    // Long symbol when the bit value differs from "bit equals active level":
    // 0 sent active or 1 sent passive is long.
    function automatic logic sym_is_long(input logic bitv, input logic act);
        return bitv ^ act;
    endfunction

    function automatic int unsigned sym_ticks(input logic bitv, input logic act,
                                              input int unsigned t_short,
                                              input int unsigned t_long);
        return sym_is_long(bitv, act) ? t_long : t_short;
    endfunction

endpackage

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/vpw_bit_shifter.sv
module vpw_bit_shifter
    import vpw_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              last_in,
    input  logic              shift,
    output logic              cur_bit,
    output logic              nxt_bit,
    output logic              final_bit,
    output logic              last_flag
);
    vpw_shift_t sh_q;

    assign cur_bit   = sh_q.data[BYTE_W-1];
    assign nxt_bit   = sh_q.data[BYTE_W-2];
    assign final_bit = (sh_q.idx == IDX_W'(BYTE_W-1));
    assign last_flag = sh_q.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q.data <= din;
            sh_q.idx  <= '0;
            sh_q.last <= last_in;
        end else if (shift) begin
            sh_q.data <= {sh_q.data[BYTE_W-2:0], 1'b0};
            sh_q.idx  <= sh_q.idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/vpw_idle_meter.sv
module vpw_idle_meter #(
    parameter int GAP_T = 300,
    localparam int GW   = $clog2(GAP_T + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bus_active,
    output logic gap_ok
);
    logic [GW-1:0] pas_q;

    assign gap_ok = (pas_q >= GW'(GAP_T));

    always_ff @(posedge clk) begin
        if (rst) begin
            pas_q <= '0;
        end else if (bus_active) begin
            pas_q <= '0;
        end else if (tick && !gap_ok) begin
            pas_q <= pas_q + GW'(1);
        end
    end
endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
    import vpw_tx_pkg::*;
#(
    parameter int T_SHORT = 64,
    parameter int T_LONG  = 128,
    parameter int T_SOF   = 200,
    parameter int T_EOD   = 200,
    parameter int T_BRK   = 300,
    parameter int T_GAP   = 300,
    localparam int T_MAX1 = (T_SOF > T_EOD) ? T_SOF : T_EOD,
    localparam int T_MAX2 = (T_BRK > T_LONG) ? T_BRK : T_LONG,
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2,
    localparam int CNT_W  = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    input  logic              byte_last,
    output logic              byte_ready,
    input  logic              brk_req,
    output logic              busy,
    output logic              bus_active
);
    vpw_state_e       state_q, state_d;
    logic             bus_q, bus_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_shift;
    logic             cur_bit, nxt_bit, final_bit, last_flag;
    logic             gap_ok;
    logic             take_first, take_next, accept;

    vpw_sym_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .tick(tick),
        .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    vpw_bit_shifter u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .din(byte_data),
        .last_in(byte_last), .shift(sh_shift), .cur_bit(cur_bit),
        .nxt_bit(nxt_bit), .final_bit(final_bit), .last_flag(last_flag)
    );

    vpw_idle_meter #(.GAP_T(T_GAP)) u_gap (
        .clk(clk), .rst(rst), .tick(tick),
        .bus_active(bus_q), .gap_ok(gap_ok)
    );

    assign take_first = (state_q == ST_IDLE) && gap_ok && !brk_req;
    assign take_next  = (state_q == ST_BITS) && tmr_done && final_bit
                        && !last_flag && !brk_req;
    assign byte_ready = take_first || take_next;
    assign accept     = byte_ready && byte_valid;

    always_comb begin
        state_d  = state_q;
        bus_d    = bus_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        if (brk_req && state_q != ST_BRK) begin
            state_d  = ST_BRK;
            bus_d    = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_BRK);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_d  = ST_SOF;
                        bus_d    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_SOF);
                        sh_load  = 1'b1;
                    end
                end
                ST_SOF: begin
                    if (tmr_done) begin
                        state_d  = ST_BITS;
                        bus_d    = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(sym_ticks(cur_bit, 1'b0, T_SHORT, T_LONG));
                    end
                end
                ST_BITS: begin
                    if (tmr_done) begin
                        tmr_load = 1'b1;
                        if (!final_bit) begin
                            sh_shift = 1'b1;
                            bus_d    = !bus_q;
                            tmr_val  = CNT_W'(sym_ticks(nxt_bit, !bus_q, T_SHORT, T_LONG));
                        end else if (accept) begin
                            sh_load  = 1'b1;
                            bus_d    = 1'b0;
                            tmr_val  = CNT_W'(sym_ticks(byte_data[BYTE_W-1], 1'b0,
                                                        T_SHORT, T_LONG));
                        end else begin
                            state_d  = ST_EOD;
                            bus_d    = 1'b0;
                            tmr_val  = CNT_W'(T_EOD);
                        end
                    end
                end
                ST_EOD: begin
                    if (tmr_done) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_BRK: begin
                    if (tmr_done) begin
                        state_d = ST_IDLE;
                        bus_d   = 1'b0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    bus_d   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bus_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bus_q   <= bus_d;
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign bus_active = bus_q;

endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk #(
    parameter int GAP_T = 300,
    localparam int GW   = $clog2(GAP_T + 1)
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic byte_valid,
    input logic byte_ready,
    input logic brk_req,
    input logic busy,
    input logic bus_active
);
    logic [GW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (bus_active) begin
            seen_q <= '0;
        end else if (tick && seen_q < GW'(GAP_T)) begin
            seen_q <= seen_q + GW'(1);
        end
    end

    p_idle_passive_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_active);

    p_sof_starts_r2: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready && !busy |=> bus_active && busy);

    p_byte_first_passive_r4: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready && busy |=> !bus_active && busy);

    p_ready_blocked_by_brk_r7: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> !byte_ready);

    p_brk_drives_r7: assert property (@(posedge clk) disable iff (rst)
        brk_req && !bus_active |=> bus_active && busy);

    p_start_gap_r8: assert property (@(posedge clk) disable iff (rst)
        byte_ready && !busy |-> seen_q >= GW'(GAP_T));

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        !tick && !brk_req && !(byte_valid && byte_ready) |=> $stable(bus_active));

endmodule

bind vpw_tx vpw_tx_chk #(.GAP_T(T_GAP)) u_vpw_tx_chk (
    .clk(clk), .rst(rst), .tick(tick), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .brk_req(brk_req), .busy(busy),
    .bus_active(bus_active)
);

// File: tb/test_vpw_tx.sv
`timescale 1ns/1ps
module test_vpw_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_valid = 1'b0;
    logic       byte_last = 1'b0;
    logic       byte_ready;
    logic       brk_req = 1'b0;
    logic       busy;
    logic       bus_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit started = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    vpw_tx i_vpw_tx (
        .clk(clk), .rst(rst), .tick(tick), .byte_data(byte_data),
        .byte_valid(byte_valid), .byte_last(byte_last), .byte_ready(byte_ready),
        .brk_req(brk_req), .busy(busy), .bus_active(bus_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- tick source ----------------
    always @(posedge clk) begin
        #1;
        if (tick_div == 0) begin
            tick = 1'b0;
        end else begin
            tick = (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
        end
    end

    // ---------------- reference model ----------------
    // kinds: 0 start, 1 data, 2 first data of byte, 3 end-of-data, 4 break, 5 idle
    localparam int K_SOF = 0, K_DAT = 1, K_DAT0 = 2, K_EOD = 3, K_BRK = 4, K_IDL = 5;
    int m_mode = 0;          // 0 idle, 1 frame, 2 break
    int cur_lvl = 0, cur_rem = 0, cur_kind = K_IDL;
    int m_idle = 0;
    bit m_last = 0;
    int q_lvl[$];
    int q_dur[$];
    int q_kind[$];

    function automatic bit m_ready();
        if (brk_req) return 0;
        if (m_mode == 0) return m_idle >= 300;
        if (m_mode == 1)
            return tick && cur_rem == 1 && q_lvl.size() == 0 &&
                   (cur_kind == K_DAT || cur_kind == K_DAT0) && !m_last;
        return 0;
    endfunction

    task automatic push_byte(input logic [7:0] b);
        int lvl;
        lvl = 0;
        for (int i = 7; i >= 0; i--) begin
            q_lvl.push_back(lvl);
            q_dur.push_back((int'(b[i]) != lvl) ? 128 : 64);
            q_kind.push_back(i == 7 ? K_DAT0 : K_DAT);
            lvl = 1 - lvl;
        end
    endtask

    task automatic set_cur(input int l, input int d, input int k);
        cur_lvl = l; cur_rem = d; cur_kind = k;
    endtask

    always @(posedge clk) begin
        bit acc;
        cycles++;
        started = 1;
        if (rst) begin
            m_mode = 0; m_idle = 0; m_last = 0;
            q_lvl.delete(); q_dur.delete(); q_kind.delete();
            set_cur(0, 0, K_IDL);
        end else begin
            acc = m_ready() && byte_valid;
            if (cur_lvl == 1) m_idle = 0;
            else if (tick && m_idle < 300) m_idle++;
            if (brk_req && m_mode != 2) begin
                m_mode = 2;
                q_lvl.delete(); q_dur.delete(); q_kind.delete();
                set_cur(1, 300, K_BRK);
            end else if (m_mode == 0) begin
                if (acc) begin
                    push_byte(byte_data);
                    m_last = byte_last;
                    set_cur(1, 200, K_SOF);
                    m_mode = 1;
                end
            end else if (tick) begin
                if (cur_rem > 1) begin
                    cur_rem--;
                end else if (m_mode == 2) begin
                    m_mode = 0;
                    set_cur(0, 0, K_IDL);
                end else begin
                    if (acc) begin
                        push_byte(byte_data);
                        m_last = byte_last;
                    end
                    if (q_lvl.size() > 0) begin
                        set_cur(q_lvl.pop_front(), q_dur.pop_front(), q_kind.pop_front());
                    end else if (cur_kind == K_DAT || cur_kind == K_DAT0) begin
                        set_cur(0, 200, K_EOD);
                    end else begin
                        m_mode = 0;
                        set_cur(0, 0, K_IDL);
                    end
                end
            end
        end
    end

    function automatic string bus_tag();
        case (cur_kind)
            K_SOF:   return "R2";
            K_DAT:   return "R3";
            K_DAT0:  return "R4";
            K_EOD:   return "R5";
            K_BRK:   return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(negedge clk) begin
        if (started && !done_run) begin
            chk(m_mode == 0 ? "R8" : bus_tag(), int'(bus_active),
                (m_mode == 0) ? 0 : cur_lvl);
            chk("R5", int'(busy), int'(m_mode != 0));
            chk(m_mode == 0 ? "R8" : "R6", int'(byte_ready), int'(m_ready()));
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cycles, 190000);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] tx_q[$];

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send_frame(input int give, input int brk_at, input int freeze_at);
        int idx;
        int cyc;
        bit acc;
        idx = 0;
        cyc = 0;
        while (idx < give) begin
            byte_valid = 1'b1;
            byte_data  = tx_q[idx];
            byte_last  = (idx == tx_q.size() - 1);
            @(negedge clk);
            acc = byte_ready;
            step();
            cyc++;
            if (acc) idx++;
            if (freeze_at > 0 && cyc == freeze_at) begin
                logic held;
                int save;
                save = tick_div;
                tick_div = 0;
                step();
                @(negedge clk);
                held = bus_active;
                for (int k = 0; k < 30; k++) begin
                    @(negedge clk);
                    chk("R9", int'(bus_active), int'(held));
                end
                tick_div = save;
                tick_cnt = 0;
                step();
            end
            if (brk_at > 0 && cyc == brk_at) begin
                byte_valid = 1'b0;
                brk_req = 1'b1;
                @(negedge clk);
                chk("R7", int'(byte_ready), 0);
                step();
                brk_req = 1'b0;
                @(negedge clk);
                chk("R7", int'(bus_active && busy), 1);
                break;
            end
        end
        byte_valid = 1'b0;
        byte_last = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        step();
    endtask

    initial begin
        repeat (4) step();
        @(negedge clk);
        chk("R1", int'(bus_active), 0);
        chk("R1", int'(busy), 0);
        chk("R1", int'(byte_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(bus_active | busy | byte_ready), 0);

        // multi-byte frame, tick every cycle
        tx_q = '{8'h00, 8'hFF, 8'hA5};
        send_frame(3, 0, 0);
        wait_idle();
        byte_valid = 1'b1; byte_data = 8'h3C; byte_last = 1'b1;
        @(negedge clk);
        chk("R8", int'(byte_ready), 0);

        // single byte frame right after gap
        tx_q = '{8'h3C};
        send_frame(1, 0, 0);
        wait_idle();

        // underrun: second byte withheld
        tx_q = '{8'h81, 8'h7E};
        send_frame(1, 0, 0);
        wait_idle();

        // slow tick with freeze
        tick_div = 3;
        tx_q = '{8'hC3, 8'h5A};
        send_frame(2, 0, 50);
        wait_idle();
        tick_div = 1;

        // break in mid frame
        tx_q = '{8'hFF, 8'h00, 8'h12};
        send_frame(3, 600, 0);
        wait_idle();

        // break held across its own pulse, then released
        brk_req = 1'b1;
        repeat (450) step();
        @(negedge clk);
        chk("R7", int'(busy), 1);
        brk_req = 1'b0;
        wait_idle();

        // break from idle, then a frame
        repeat (20) step();
        brk_req = 1'b1;
        step();
        brk_req = 1'b0;
        wait_idle();
        tx_q = '{8'h96, 8'h69};
        send_frame(2, 0, 0);
        wait_idle();
        repeat (10) step();
        finish_run();
    end

endmodule